// File: doc/BRIEF.md
# Typed-Entry Associative Store

This block is a small content-addressable store of `DEPTH` words of `WIDTH` bits. Each word can be reached in two ways: by address, for ordinary reads and writes, or by content, through a compare against a held search key. Every word also carries a two-bit type code. The type decides whether the word takes part in a search. It also lets the store report its fullness and the first free slot.

A single command port accepts one operation per clock.

- **Search key and mask.** Loading the search key starts an automatic search over ordinary entries. A forced search runs the held key against any one chosen entry type. A mask register turns selected key bits into don't-cares. A split setting limits the search to the low 16-bit segments of each word, so the remaining segments act as uncompared payload.
- **Key shifting.** The held key can be rotated left or right by one bit per command, to support near-match sweeps.
- **Search results.** A priority encoder returns the lowest matching address, together with a hit flag and a multiple-hit flag.
- **Free-slot tracking.** A second encoder over the Empty entries drives the full flag and the next-free address.

Top module: `assoc_store`

## Requirements
- R1: After reset, every entry is of type Empty and its data is zero. The held key and the mask are zero. `match_flag`, `multi_flag` and `full_flag` are low, and `match_addr`, `next_free`, `rd_data` and `rd_vbits` are zero.
- R2: The type code is the pair {skip, empty}, with the skip bit as bit 1. The codes are 2'b00 Valid, 2'b01 Empty, 2'b10 Skip and 2'b11 RAM. Op 3 (SETTYPE) writes `cmd_type` as the type of entry `cmd_addr`.
- R3: Op 4 (LOADKEY) stores `cmd_data` as the held key and searches with that new key. The search considers only Valid entries.
- R4: Op 6 (SEARCH) searches with the held key. The search considers only entries whose type equals `cmd_type`, whichever of the four codes that is.
- R5: A mask bit at 1 makes that key position a don't-care for every entry. The mask is loaded by op 5 (LOADMASK).
- R6: The compared field is bits [16*(k+1)-1:0], where k is the value of `cfg_cam_segs` (0 to 3). Bits above that field never affect a search.
- R7: When several entries hit, `match_addr` is the lowest hitting address. `multi_flag` is high only when more than one entry hits. When nothing hits, both flags are low and `match_addr` is 0.
- R8: Search results appear on the clock edge that accepts the search op. They hold unchanged through every other op, including writes and type changes to the entry they point at.
- R9: `full_flag` is high exactly when no entry is Empty. `next_free` is the lowest Empty address, or 0 when the store is full. Both follow the type state from the edge after a type change.
- R10: Op 7 (SHL) rotates the held key left by one bit, so the MSB moves to bit 0. Op 8 (SHR) rotates it right by one bit, so bit 0 moves to the MSB.
- R11: Op 1 (WRITE) stores `cmd_data` at `cmd_addr` without changing the entry's type. Op 2 (READ) returns the word on `rd_data` and its type code on `rd_vbits` one edge later, and both hold until the next READ. Op 0 does nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_cam_segs | input | $clog2(WIDTH/SEG_W) | Compared width in segments, minus one |
| cmd_op | input | 4 | Operation code |
| cmd_addr | input | $clog2(DEPTH) | Entry address for WRITE, READ, SETTYPE |
| cmd_type | input | 2 | Type code for SETTYPE and SEARCH |
| cmd_data | input | WIDTH | Write data, key or mask value |
| match_flag | output | 1 | At least one entry hit in the last search |
| multi_flag | output | 1 | More than one entry hit in the last search |
| match_addr | output | $clog2(DEPTH) | Lowest hitting address |
| full_flag | output | 1 | No Empty entry remains |
| next_free | output | $clog2(DEPTH) | Lowest Empty address |
| rd_data | output | WIDTH | Word returned by the last READ |
| rd_vbits | output | 2 | Type code returned by the last READ |

## Verification
Two results can move apart within a single cycle. The held search result is one. The free-slot flags, which track the live type array, are the other. The bench provokes this by searching, then at once rewriting and retyping to Empty the very entry the search reported. On the following edges it expects the hit flags and address to stay fixed while `full_flag` drops and `next_free` moves to that entry. A reference model of the store, built from plain arrays and loops, is compared against every output after every clock.

// File: rtl/assoc_store_pkg.sv
package assoc_store_pkg;

   typedef enum logic [1:0] {
      ET_VALID = 2'b00,
      ET_EMPTY = 2'b01,
      ET_SKIP  = 2'b10,
      ET_RAM   = 2'b11
   } etype_e;

   typedef enum logic [3:0] {
      OP_NOP      = 4'd0,
      OP_WRITE    = 4'd1,
      OP_READ     = 4'd2,
      OP_SETTYPE  = 4'd3,
      OP_LOADKEY  = 4'd4,
      OP_LOADMASK = 4'd5,
      OP_SEARCH   = 4'd6,
      OP_SHL      = 4'd7,
      OP_SHR      = 4'd8
   } op_e;

endpackage

// File: rtl/assoc_store_prio.sv
module assoc_store_prio #(
   parameter int N  = 16,
   localparam int AW = $clog2(N)
) (
   input  logic [N-1:0]  req,
   output logic          any,
   output logic          multi,
   output logic [AW-1:0] idx
);

   generate
      if (N < 2) begin : g_bad_n
         $error("assoc_store_prio needs N >= 2");
      end
   endgenerate

   // Scan from the top down, so the lowest requester is the last to win.
   always_comb begin
      idx = '0;
      any = 1'b0;
      for (int i = N - 1; i >= 0; i--) begin
         if (req[i]) begin
            idx = AW'(i);
            any = 1'b1;
         end
      end
   end

   // Clearing the lowest set bit leaves something only if two or more were set.
   assign multi = |(req & (req - N'(1)));

endmodule

// File: rtl/assoc_store_match.sv
module assoc_store_match
   import assoc_store_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int WIDTH = 64,
   parameter int SEG_W = 16,
   localparam int NSEG = WIDTH / SEG_W,
   localparam int SSW  = $clog2(NSEG)
) (
   input  logic [DEPTH-1:0][WIDTH-1:0] words,
   input  logic [DEPTH-1:0][1:0]       vbits,
   input  logic [WIDTH-1:0]            key,
   input  logic [WIDTH-1:0]            mask,
   input  logic [SSW-1:0]              cam_segs,
   input  logic [1:0]                  want,
   output logic [DEPTH-1:0]            hits
);

   logic [WIDTH-1:0] seg_care;
   logic [WIDTH-1:0] care;

   // A segment takes part in the search when its index is within the split.
   genvar s;
   generate
      for (s = 0; s < NSEG; s++) begin : g_seg
         assign seg_care[s*SEG_W +: SEG_W] = {SEG_W{(SSW'(s) <= cam_segs)}};
      end
   endgenerate

   assign care = seg_care & ~mask;

   genvar e;
   generate
      for (e = 0; e < DEPTH; e++) begin : g_ent
         assign hits[e] = (vbits[e] == want) && (((words[e] ^ key) & care) == '0);
      end
   endgenerate

endmodule

// File: rtl/assoc_store.sv
module assoc_store
   import assoc_store_pkg::*;
#(
   parameter int DEPTH = 16,
   parameter int WIDTH = 64,
   parameter int SEG_W = 16,
   localparam int AW   = $clog2(DEPTH),
   localparam int NSEG = WIDTH / SEG_W,
   localparam int SSW  = $clog2(NSEG)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SSW-1:0]   cfg_cam_segs,
   input  logic [3:0]       cmd_op,
   input  logic [AW-1:0]    cmd_addr,
   input  logic [1:0]       cmd_type,
   input  logic [WIDTH-1:0] cmd_data,
   output logic             match_flag,
   output logic             multi_flag,
   output logic [AW-1:0]    match_addr,
   output logic             full_flag,
   output logic [AW-1:0]    next_free,
   output logic [WIDTH-1:0] rd_data,
   output logic [1:0]       rd_vbits
);

   // Elaboration-time checks on the parameters.
   generate
      if (DEPTH < 2 || (1 << AW) != DEPTH) begin : g_bad_depth
         $error("DEPTH must be a power of two, at least 2");
      end
      if (SEG_W < 1 || (WIDTH % SEG_W) != 0) begin : g_bad_seg
         $error("WIDTH must be a whole number of segments");
      end
      if (NSEG < 2 || (1 << SSW) != NSEG) begin : g_bad_nseg
         $error("segment count must be a power of two, at least 2");
      end
   endgenerate

   logic [DEPTH-1:0][WIDTH-1:0] mem_q;
   logic [DEPTH-1:0][1:0]       vb_q;
   logic [WIDTH-1:0]            key_q;
   logic [WIDTH-1:0]            mask_q;

   logic             do_search;
   logic [WIDTH-1:0] srch_key;
   logic [1:0]       srch_want;
   logic [DEPTH-1:0] hits;
   logic             hit_any;
   logic             hit_multi;
   logic [AW-1:0]    hit_idx;
   logic [DEPTH-1:0] empties;
   logic             free_any;
   logic             free_multi;
   logic [AW-1:0]    free_idx;

   // A key load searches Valid entries with the new key; a forced search
   // uses the held key and the requested type.
   assign do_search = (cmd_op == OP_LOADKEY) || (cmd_op == OP_SEARCH);
   assign srch_key  = (cmd_op == OP_LOADKEY) ? cmd_data : key_q;
   assign srch_want = (cmd_op == OP_LOADKEY) ? 2'(ET_VALID) : cmd_type;

   assoc_store_match #(
      .DEPTH (DEPTH),
      .WIDTH (WIDTH),
      .SEG_W (SEG_W)
   ) match_i (
      .words    (mem_q),
      .vbits    (vb_q),
      .key      (srch_key),
      .mask     (mask_q),
      .cam_segs (cfg_cam_segs),
      .want     (srch_want),
      .hits     (hits)
   );

   assoc_store_prio #(.N(DEPTH)) hit_enc_i (
      .req   (hits),
      .any   (hit_any),
      .multi (hit_multi),
      .idx   (hit_idx)
   );

   genvar e;
   generate
      for (e = 0; e < DEPTH; e++) begin : g_empty
         assign empties[e] = (vb_q[e] == 2'(ET_EMPTY));
      end
   endgenerate

   assoc_store_prio #(.N(DEPTH)) free_enc_i (
      .req   (empties),
      .any   (free_any),
      .multi (free_multi),
      .idx   (free_idx)
   );

   assign full_flag = ~free_any;
   assign next_free = free_idx;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         mem_q      <= '0;
         vb_q       <= {DEPTH{2'(ET_EMPTY)}};
         key_q      <= '0;
         mask_q     <= '0;
         match_flag <= 1'b0;
         multi_flag <= 1'b0;
         match_addr <= '0;
         rd_data    <= '0;
         rd_vbits   <= '0;
      end else begin
         case (cmd_op)
            OP_WRITE:    mem_q[cmd_addr] <= cmd_data;
            OP_READ: begin
               rd_data  <= mem_q[cmd_addr];
               rd_vbits <= vb_q[cmd_addr];
            end
            OP_SETTYPE:  vb_q[cmd_addr] <= cmd_type;
            OP_LOADKEY:  key_q <= cmd_data;
            OP_LOADMASK: mask_q <= cmd_data;
            OP_SHL:      key_q <= {key_q[WIDTH-2:0], key_q[WIDTH-1]};
            OP_SHR:      key_q <= {key_q[0], key_q[WIDTH-1:1]};
            default: ;
         endcase
         if (do_search) begin
            match_flag <= hit_any;
            multi_flag <= hit_multi;
            match_addr <= hit_idx;
         end
      end
   end

endmodule

// File: rtl/assoc_store_chk.sv
module assoc_store_chk
   import assoc_store_pkg::*;
#(
   parameter int AW = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic [3:0]    cmd_op,
   input logic [AW-1:0] cmd_addr,
   input logic [1:0]    cmd_type,
   input logic          match_flag,
   input logic          multi_flag,
   input logic [AW-1:0] match_addr,
   input logic          full_flag,
   input logic [AW-1:0] next_free,
   input logic [1:0]    rd_vbits
);

   AST_MULTI_NEEDS_HIT: assert property (@(posedge clk) disable iff (!rst_n)
      multi_flag |-> match_flag); // R7

   AST_RESULT_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
      !(cmd_op == OP_LOADKEY || cmd_op == OP_SEARCH)
      |=> ($stable(match_flag) && $stable(multi_flag) && $stable(match_addr))); // R8

   AST_FREED_SLOT_SEEN: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == OP_SETTYPE && cmd_type == ET_EMPTY)
      |=> (!full_flag && next_free <= $past(cmd_addr))); // R9

   AST_FULL_FREE_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
      full_flag |-> (next_free == '0)); // R9

   AST_TYPE_READBACK: assert property (@(posedge clk) disable iff (!rst_n)
      (cmd_op == OP_READ && $past(cmd_op) == OP_SETTYPE && cmd_addr == $past(cmd_addr))
      |=> (rd_vbits == $past(cmd_type, 2))); // R2

endmodule

bind assoc_store assoc_store_chk #(.AW(AW)) chk_i (
   .clk        (clk),
   .rst_n      (rst_n),
   .cmd_op     (cmd_op),
   .cmd_addr   (cmd_addr),
   .cmd_type   (cmd_type),
   .match_flag (match_flag),
   .multi_flag (multi_flag),
   .match_addr (match_addr),
   .full_flag  (full_flag),
   .next_free  (next_free),
   .rd_vbits   (rd_vbits)
);

// File: tb/assoc_store_tb_top.sv
module assoc_store_tb_top;
   import assoc_store_pkg::*;

   localparam int DEPTH = 16;
   localparam int WIDTH = 64;
   localparam int SEG_W = 16;
   localparam int AW    = $clog2(DEPTH);
   localparam int SSW   = $clog2(WIDTH / SEG_W);

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic [SSW-1:0]   cfg_cam_segs = '1;
   logic [3:0]       cmd_op = OP_NOP;
   logic [AW-1:0]    cmd_addr = '0;
   logic [1:0]       cmd_type = '0;
   logic [WIDTH-1:0] cmd_data = '0;
   logic             match_flag, multi_flag, full_flag;
   logic [AW-1:0]    match_addr, next_free;
   logic [WIDTH-1:0] rd_data;
   logic [1:0]       rd_vbits;

   always #10 clk = ~clk;

   assoc_store #(.DEPTH(DEPTH), .WIDTH(WIDTH), .SEG_W(SEG_W)) dut_i (
      .clk, .rst_n, .cfg_cam_segs, .cmd_op, .cmd_addr, .cmd_type, .cmd_data,
      .match_flag, .multi_flag, .match_addr, .full_flag, .next_free,
      .rd_data, .rd_vbits
   );

   // Reference model state
   logic [WIDTH-1:0] m_mem [DEPTH];
   logic [1:0]       m_typ [DEPTH];
   logic [WIDTH-1:0] m_key, m_mask;
   logic             e_match, e_multi;
   logic [AW-1:0]    e_addr;
   logic [WIDTH-1:0] e_rd;
   logic [1:0]       e_rdv;
   int vectors = 0;
   int fails = 0;
   bit done = 0;

   task automatic model_search(input logic [WIDTH-1:0] key, input logic [1:0] want);
      int n = 0;
      e_match = 0; e_multi = 0; e_addr = '0;
      for (int i = 0; i < DEPTH; i++) begin
         bit hit = (m_typ[i] == want);
         for (int b = 0; b < WIDTH; b++)
            if (b < SEG_W * (int'(cfg_cam_segs) + 1) && !m_mask[b] && m_mem[i][b] != key[b])
               hit = 0;
         if (hit) begin
            if (n == 0) e_addr = AW'(i);
            n++;
         end
      end
      e_match = (n > 0);
      e_multi = (n > 1);
   endtask

   task automatic check_all(input string tag);
      bit e_full = 1;
      logic [AW-1:0] e_free = '0;
      for (int i = DEPTH - 1; i >= 0; i--)
         if (m_typ[i] == ET_EMPTY) begin e_full = 0; e_free = AW'(i); end
      vectors++;
      if (match_flag !== e_match) begin fails++;
         $display("FAIL %s match_flag act=%0b exp=%0b", tag, match_flag, e_match); end
      if (multi_flag !== e_multi) begin fails++;
         $display("FAIL %s multi_flag act=%0b exp=%0b", tag, multi_flag, e_multi); end
      if (match_addr !== e_addr) begin fails++;
         $display("FAIL %s match_addr act=%0d exp=%0d", tag, match_addr, e_addr); end
      if (full_flag !== e_full) begin fails++;
         $display("FAIL %s full_flag act=%0b exp=%0b", tag, full_flag, e_full); end
      if (next_free !== e_free) begin fails++;
         $display("FAIL %s next_free act=%0d exp=%0d", tag, next_free, e_free); end
      if (rd_data !== e_rd) begin fails++;
         $display("FAIL %s rd_data act=%h exp=%h", tag, rd_data, e_rd); end
      if (rd_vbits !== e_rdv) begin fails++;
         $display("FAIL %s rd_vbits act=%b exp=%b", tag, rd_vbits, e_rdv); end
   endtask

   // Drive one op at the falling edge, advance the model, compare mid-cycle.
   task automatic apply(input logic [3:0] op, input int addr, input logic [1:0] typ,
                        input logic [WIDTH-1:0] data, input string tag);
      cmd_op = op; cmd_addr = AW'(addr); cmd_type = typ; cmd_data = data;
      case (op)
         OP_WRITE:    m_mem[addr] = data;
         OP_READ:     begin e_rd = m_mem[addr]; e_rdv = m_typ[addr]; end
         OP_SETTYPE:  m_typ[addr] = typ;
         OP_LOADKEY:  begin model_search(data, ET_VALID); m_key = data; end
         OP_LOADMASK: m_mask = data;
         OP_SEARCH:   model_search(m_key, typ);
         OP_SHL:      m_key = {m_key[WIDTH-2:0], m_key[WIDTH-1]};
         OP_SHR:      m_key = {m_key[0], m_key[WIDTH-1:1]};
         default: ;
      endcase
      @(posedge clk);
      @(negedge clk);
      check_all(tag);
   endtask

   localparam logic [WIDTH-1:0] BASE = 64'hA5C3_0000_0000_0000;

   initial begin
      for (int i = 0; i < DEPTH; i++) begin m_mem[i] = '0; m_typ[i] = ET_EMPTY; end
      m_key = '0; m_mask = '0; e_match = 0; e_multi = 0; e_addr = '0; e_rd = '0; e_rdv = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      check_all("R1 reset state");

      // Write every word; types stay Empty (R11)
      for (int i = 0; i < DEPTH; i++) apply(OP_WRITE, i, 2'b00, BASE | 64'(i), "R11 write");
      apply(OP_READ, 3, 2'b00, '0, "R11 read empty entry");
      apply(OP_NOP, 0, 2'b00, '0, "R11 read result holds");

      // Retype: all Valid except one Skip and one RAM; fullness tracks (R9, R2)
      for (int i = 0; i < DEPTH; i++)
         apply(OP_SETTYPE, i, (i == 5) ? 2'b10 : (i == 6) ? 2'b11 : 2'b00, '0, "R9 fill");
      apply(OP_READ, 5, 2'b00, '0, "R2 read skip type");
      apply(OP_READ, 6, 2'b00, '0, "R2 read ram type");

      // Duplicate entry 4 into 9: lowest wins, multiple flagged (R3, R7)
      apply(OP_WRITE, 9, 2'b00, BASE | 64'd4, "R11 dup write");
      apply(OP_LOADKEY, 0, 2'b00, BASE | 64'd4, "R7 lowest of two");
      apply(OP_LOADKEY, 0, 2'b00, BASE | 64'd7, "R3 single hit");
      apply(OP_LOADKEY, 0, 2'b00, BASE | 64'd5, "R3 skip entry ignored");
      apply(OP_SEARCH, 0, 2'b10, '0, "R4 forced skip search");
      apply(OP_LOADKEY, 0, 2'b00, BASE | 64'd6, "R3 ram entry ignored");
      apply(OP_SEARCH, 0, 2'b11, '0, "R4 forced ram search");
      apply(OP_SEARCH, 0, 2'b01, '0, "R4 forced empty search none");
      apply(OP_LOADKEY, 0, 2'b00, 64'h1234_5678_9ABC_DEF0, "R7 no hit");

      // Mask: low nibble don't-care (R5)
      apply(OP_LOADMASK, 0, 2'b00, 64'hF, "R5 load mask");
      apply(OP_LOADKEY, 0, 2'b00, BASE | 64'hC, "R5 masked search");
      apply(OP_LOADMASK, 0, 2'b00, 64'h0, "R5 clear mask");
      apply(OP_LOADKEY, 0, 2'b00, BASE | 64'hC, "R5 unmasked search");

      // Split: only low segment compared when cfg is 0 (R6)
      cfg_cam_segs = 2'd0;
      apply(OP_LOADKEY, 0, 2'b00, 64'hFFFF_0000_0000_000B, "R6 one segment");
      cfg_cam_segs = 2'd1;
      apply(OP_LOADKEY, 0, 2'b00, 64'hFFFF_0000_0000_000B, "R6 two segments");
      cfg_cam_segs = 2'd3;
      apply(OP_LOADKEY, 0, 2'b00, 64'hFFFF_0000_0000_000B, "R6 four segments");

      // Hold: result kept while its entry is rewritten and freed (R8, R9)
      apply(OP_LOADKEY, 0, 2'b00, BASE | 64'd10, "R8 search");
      apply(OP_WRITE, 10, 2'b00, 64'h0, "R8 rewrite hit entry");
      apply(OP_SETTYPE, 10, 2'b01, '0, "R8 free hit entry");
      apply(OP_READ, 10, 2'b00, '0, "R8 read freed entry");
      apply(OP_SETTYPE, 2, 2'b01, '0, "R9 lower free slot");
      apply(OP_SEARCH, 0, 2'b00, '0, "R8 re-search");

      // Rotations (R10)
      apply(OP_WRITE, 0, 2'b00, 64'h0000_0000_0000_0003, "R10 prep");
      apply(OP_WRITE, 1, 2'b00, 64'hC000_0000_0000_0000, "R10 prep");
      apply(OP_LOADKEY, 0, 2'b00, 64'h8000_0000_0000_0001, "R10 load key");
      apply(OP_SHL, 0, 2'b00, '0, "R10 rotate left");
      apply(OP_SEARCH, 0, 2'b00, '0, "R10 left result");
      apply(OP_SHR, 0, 2'b00, '0, "R10 rotate right");
      apply(OP_SHR, 0, 2'b00, '0, "R10 rotate right");
      apply(OP_SEARCH, 0, 2'b00, '0, "R10 right result");

      // Empty everything again (R9)
      for (int i = 0; i < DEPTH; i++) apply(OP_SETTYPE, i, 2'b01, '0, "R9 drain");
      apply(OP_NOP, 0, 2'b00, '0, "R11 nop");

      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         fails++;
         $display("FAIL watchdog expired act=running exp=finished");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
         $finish;
      end
   end

endmodule